// File: doc/BRIEF.md
# I2S Master Serial Audio Transmitter

The block is a master-mode transmitter for a three-wire serial audio link. From the system clock it makes the bit clock and the word-select line. It sends left and right samples, time-multiplexed, on one data line. A producer offers a left/right sample pair through a valid/ready handshake. The block accepts one pair at the start of every frame and serializes it. If no pair is offered at that point, the previous pair is sent again and a sticky underrun flag is raised.

Five settings are chosen at run time:
- the frame length (32, 48 or 64 bit clocks, split evenly between the two channels);
- the sample width (16, 18, 20 or 24 bits);
- left or right justification inside a channel slot;
- MSB-first or LSB-first bit order;
- one of three framing formats, which differ in word-select polarity and in whether data lags word-select by one bit clock.

All settings, including the bit-clock divisor, are sampled only when a frame starts. A frame is therefore never sent with mixed settings. Data and word-select change only with the falling bit-clock edge, so a receiver can sample them on the rising edge. When disabled, all line outputs are held low.

Top module: `i2s_tx_master`

## Requirements
- R1: While enabled, `sck_o` is a square wave with period 2*(`div_i`+1) system clocks. `ws_o` and `sd_o` change only in the cycle where `sck_o` falls, or when the block is disabled, so they are steady for every rising edge.
- R2: `slot_sel_i` sets the channel slot length: 0 gives 16 bit clocks, 1 gives 24, and 2 or 3 gives 32. A frame is two slots, left first, then right.
- R3: `width_sel_i` sets the sample width W: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24. Only bits W-1..0 of `s_left_i` and `s_right_i` are sent, and higher input bits have no effect.
- R4: Slot position b (0 is the first bit clock of the slot) carries sample bit position p = b when `rjust_i`=0, or p = b-(S-W) when `rjust_i`=1, where S is the slot length. Positions with p outside 0..W-1 carry 0.
- R5: With `lsb_first_i`=0, position p sends sample bit W-1-p. With `lsb_first_i`=1 it sends sample bit p.
- R6: `ws_o` is 0 during the left slot and 1 during the right slot for `fmt_i` values 0, 1 and 3. It is inverted for `fmt_i`=2.
- R7: With `fmt_i` 0 or 3, `sd_o` lags the R4/R5 bit stream by one bit clock. The first bit of a frame is the last bit of the previous frame, or 0 right after enable. With `fmt_i` 1 or 2 there is no lag.
- R8: Slot positions not covered by sample bits are sent as 0, even when the input bits are ones.
- R9: `s_ready_o` is high for exactly one system cycle at each frame start: on the enable cycle, and at the falling edge that ends the last bit of a frame. When `s_valid_i` is high in that cycle, the offered pair is used for the new frame.
- R10: When a frame starts with `s_valid_i` low, the previous pair is sent again and `underrun_o` rises in the next cycle. It stays high until `en_i` goes low.
- R11: Changes to the settings or to `div_i` during a frame do not affect that frame. They apply from the next frame start.
- R12: After reset, and from the cycle after `en_i` is low, `sck_o`, `ws_o`, `sd_o`, `underrun_o` and `s_ready_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmit enable |
| div_i | input | DIV_W | Bit-clock half period minus one, in system clocks |
| slot_sel_i | input | 2 | Slot length code |
| width_sel_i | input | 2 | Sample width code |
| rjust_i | input | 1 | 1 = right-justified in slot |
| lsb_first_i | input | 1 | 1 = LSB sent first |
| fmt_i | input | 2 | Framing format code |
| s_valid_i | input | 1 | Sample pair offered |
| s_ready_o | output | 1 | Sample pair taken this cycle |
| s_left_i | input | SAMPLE_W | Left sample |
| s_right_i | input | SAMPLE_W | Right sample |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The hardest cases to reach from the ports are those at a frame boundary.

One is the one-bit lag in the delayed format. There, the first bit of a frame must come from the previous frame's data and settings. This is hit by running every combination of slot, width, justification, order and format over several back-to-back frames, each frame with new random data.

The other is a settings change in the middle of a frame. The bench changes every setting ten bit clocks into a frame. It also withholds valid for exactly one chosen frame, so the repeat path and the underrun flag are exercised at a known frame.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_WSHI = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [1:0] slot;
    logic [1:0] width;
    logic       rjust;
    logic       lsb_first;
    fmt_e       fmt;
  } cfg_t;

  function automatic logic [6:0] slot_len(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd16;
      2'd1:    return 7'd24;
      default: return 7'd32;
    endcase
  endfunction

  function automatic logic [6:0] width_len(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd16;
      2'd1:    return 7'd18;
      2'd2:    return 7'd20;
      default: return 7'd24;
    endcase
  endfunction

  function automatic logic is_delayed(input fmt_e f);
    return (f == FMT_I2S) || (f == FMT_RSV);
  endfunction

endpackage

// File: rtl/i2s_sck_gen.sv
module i2s_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sck_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == half_i);
  assign fall_o = tick && sck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_o <= ~sck_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/i2s_bit_pick.sv
module i2s_bit_pick
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int POS_W    = 7
) (
  input  cfg_t                cfg_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic [POS_W-1:0]    pos_i,
  output logic                right_o,
  output logic                bit_o
);

  localparam int PW = POS_W + 2;

  logic [6:0]          s_len, w_len;
  logic [POS_W-1:0]    b;
  logic signed [PW-1:0] p;
  logic [PW-1:0]       idx;
  logic                in_rng;
  logic [SAMPLE_W-1:0] smp, shifted;

  always_comb begin
    s_len   = slot_len(cfg_i.slot);
    w_len   = width_len(cfg_i.width);
    right_o = ({1'b0, pos_i} >= {1'b0, s_len});
    b       = right_o ? pos_i - POS_W'(s_len) : pos_i;
    if (cfg_i.rjust)
      p = $signed(PW'(b)) + $signed(PW'(w_len)) - $signed(PW'(s_len));
    else
      p = $signed(PW'(b));
    in_rng  = (p >= 0) && (p < $signed(PW'(w_len)));
    idx     = cfg_i.lsb_first ? $unsigned(p) : (PW'(w_len) - PW'(1) - $unsigned(p));
    smp     = right_o ? right_i : left_i;
    shifted = smp >> idx;
    bit_o   = in_rng & shifted[0];
  end

endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
  import i2s_tx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int SAMPLE_W  = 24,
  parameter int MAX_FRAME = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [1:0]          slot_sel_i,
  input  logic [1:0]          width_sel_i,
  input  logic                rjust_i,
  input  logic                lsb_first_i,
  input  logic [1:0]          fmt_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [SAMPLE_W-1:0] s_left_i,
  input  logic [SAMPLE_W-1:0] s_right_i,
  output logic                sck_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underrun_o
);

  localparam int POS_W = $clog2(MAX_FRAME);

  logic                run_q;
  logic [DIV_W-1:0]    div_q;
  cfg_t                cfg_q, cfg_n, cfg_in;
  logic [SAMPLE_W-1:0] left_q, right_q, left_n, right_n;
  logic [POS_W-1:0]    pos_q, pos_n;
  logic                ws_q, sd_q, u_prev_q, ur_q;
  logic                fall, last, start, wrap, adv, load;
  logic [POS_W:0]      frame_len;
  logic                u_n, ch_n, ws_n, sd_n;

  i2s_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q && en_i),
    .half_i (div_q),
    .sck_o  (sck_o),
    .fall_o (fall)
  );

  assign cfg_in = '{slot: slot_sel_i, width: width_sel_i, rjust: rjust_i,
                    lsb_first: lsb_first_i, fmt: fmt_e'(fmt_i)};

  assign frame_len = (POS_W+1)'({slot_len(cfg_q.slot), 1'b0});
  assign last      = ({1'b0, pos_q} == frame_len - 1'b1);
  assign start     = en_i && !run_q;
  assign wrap      = en_i && run_q && fall && last;
  assign adv       = en_i && run_q && fall && !last;
  assign load      = start || wrap;
  assign s_ready_o = load;

  // next-bit state: settings and data switch only at a frame start
  assign cfg_n   = load ? cfg_in : cfg_q;
  assign left_n  = (load && s_valid_i) ? s_left_i  : left_q;
  assign right_n = (load && s_valid_i) ? s_right_i : right_q;
  assign pos_n   = load ? '0 : (adv ? pos_q + 1'b1 : pos_q);

  i2s_bit_pick #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_pick (
    .cfg_i   (cfg_n),
    .left_i  (left_n),
    .right_i (right_n),
    .pos_i   (pos_n),
    .right_o (ch_n),
    .bit_o   (u_n)
  );

  assign ws_n = (cfg_n.fmt == FMT_WSHI) ? ~ch_n : ch_n;
  assign sd_n = is_delayed(cfg_n.fmt) ? (start ? 1'b0 : u_prev_q) : u_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      div_q    <= '0;
      cfg_q    <= '0;
      left_q   <= '0;
      right_q  <= '0;
      pos_q    <= '0;
      ws_q     <= 1'b0;
      sd_q     <= 1'b0;
      u_prev_q <= 1'b0;
      ur_q     <= 1'b0;
    end else if (!en_i) begin
      run_q    <= 1'b0;
      pos_q    <= '0;
      ws_q     <= 1'b0;
      sd_q     <= 1'b0;
      u_prev_q <= 1'b0;
      ur_q     <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (load || adv) begin
        pos_q    <= pos_n;
        ws_q     <= ws_n;
        sd_q     <= sd_n;
        u_prev_q <= u_n;
      end
      if (load) begin
        cfg_q   <= cfg_n;
        div_q   <= div_i;
        left_q  <= left_n;
        right_q <= right_n;
      end
      ur_q <= ur_q | (load & ~s_valid_i);
    end
  end

  assign ws_o       = ws_q;
  assign sd_o       = sd_q;
  assign underrun_o = ur_q;

endmodule

// File: rtl/i2s_tx_master_chk.sv
module i2s_tx_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic s_valid_i,
  input logic s_ready_o,
  input logic sck_o,
  input logic ws_o,
  input logic sd_o,
  input logic underrun_o
);

  a_r1_lines_steady_while_sck_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> ($stable(ws_o) && $stable(sd_o)));

  a_r9_ready_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |=> !s_ready_o);

  a_r9_ready_only_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> en_i);

  a_r10_underrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ready_o && !s_valid_i) |=> underrun_o);

  a_r10_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && en_i) |=> underrun_o);

  a_r12_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sck_o && !ws_o && !sd_o && !underrun_o));

endmodule

bind i2s_tx_master i2s_tx_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .s_valid_i  (s_valid_i),
  .s_ready_o  (s_ready_o),
  .sck_o      (sck_o),
  .ws_o       (ws_o),
  .sd_o       (sd_o),
  .underrun_o (underrun_o)
);

// File: tb/i2s_tx_master_tb.sv
`timescale 1ns/1ps
module i2s_tx_master_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  div = '0;
  logic [1:0]  slot_sel = '0, width_sel = '0, fmt = '0;
  logic        rjust = 1'b0, lsb_first = 1'b0;
  logic        s_valid = 1'b0;
  logic [23:0] drv_l = '0, drv_r = '0;
  logic        s_ready, sck, ws, sd, underrun;

  always #4 clk = ~clk;

  i2s_tx_master u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .div_i(div),
    .slot_sel_i(slot_sel), .width_sel_i(width_sel), .rjust_i(rjust),
    .lsb_first_i(lsb_first), .fmt_i(fmt), .s_valid_i(s_valid),
    .s_ready_o(s_ready), .s_left_i(drv_l), .s_right_i(drv_r),
    .sck_o(sck), .ws_o(ws), .sd_o(sd), .underrun_o(underrun)
  );

  int n_vec = 0, n_bad = 0;
  int seed = 1, ur_frame = -1;
  string ctx = "sweep";

  int          f_slot[8], f_w[8], f_rj[8], f_lsb[8], f_fmt[8];
  logic [23:0] f_l[8], f_r[8];
  int nf = 0, cf = 0, ct = 0, cyc = 0, idle_cnt = 0;
  bit exp_ur = 0, have_rise = 0, prev_sck = 0, pend = 0;

  function automatic int slen(int c); return (c == 0) ? 16 : (c == 1) ? 24 : 32; endfunction
  function automatic int wlen(int c); return (c == 0) ? 16 : (c == 1) ? 18 : (c == 2) ? 20 : 24; endfunction

  function automatic logic [23:0] gen(int s, int n, int c);
    logic [31:0] x;
    x = 32'(s) * 32'h9E3779B1 + 32'(n) * 32'h85EBCA6B + 32'(c) * 32'hC2B2AE35;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    return x[23:0];
  endfunction

  function automatic bit u_bit(int f, int t);
    int s, w, b, p, idx;
    bit ch;
    logic [23:0] d;
    s = slen(f_slot[f]); w = wlen(f_w[f]);
    ch = (t >= s);
    b = ch ? t - s : t;
    p = f_rj[f] ? b - (s - w) : b;
    if (p < 0 || p >= w) return 1'b0;
    idx = f_lsb[f] ? p : w - 1 - p;
    d = ch ? f_r[f] : f_l[f];
    return d[idx];
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d t=%0t", req, ctx, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      if (!en) begin
        idle_cnt++;
        if (idle_cnt >= 2) begin
          // R12: idle outputs while disabled
          chk(!sck && !ws && !sd && !underrun && !s_ready, "R12",
              {sck, ws, sd, underrun, s_ready}, 0);
        end
        nf = 0; cf = 0; ct = 0; cyc = 0; exp_ur = 0; have_rise = 0; prev_sck = 0; pend = 0;
        drv_l = gen(seed, 0, 0); drv_r = gen(seed, 0, 1);
        s_valid = (ur_frame != 0);
      end else begin
        idle_cnt = 0;
        if (pend) begin
          drv_l = gen(seed, nf, 0); drv_r = gen(seed, nf, 1);
          s_valid = (ur_frame != nf);
          pend = 0;
        end
        cyc++;
        chk(underrun == exp_ur, "R10", underrun, exp_ur);
        if (sck && !prev_sck) begin
          int t, s, ev_sd;
          bit ev_ws, rc;
          if (have_rise) chk(cyc == 2 * (div + 1), "R1", cyc, 2 * (int'(div) + 1));
          have_rise = 1; cyc = 0;
          if (ct == 2 * slen(f_slot[cf])) begin cf++; ct = 0; end
          t = ct; s = slen(f_slot[cf]);
          rc = (t >= s);
          ev_ws = (f_fmt[cf] == 2) ? !rc : rc;
          chk(ws == ev_ws, "R6", ws, ev_ws);
          if (f_fmt[cf] == 0 || f_fmt[cf] == 3) begin
            if (t != 0)      ev_sd = u_bit(cf, t - 1);
            else if (cf == 0) ev_sd = 0;
            else             ev_sd = u_bit(cf - 1, 2 * slen(f_slot[cf - 1]) - 1);
            chk(sd == ev_sd[0], "R7 (R2/R3/R4/R5/R8)", sd, ev_sd);
          end else begin
            ev_sd = u_bit(cf, t);
            chk(sd == ev_sd[0], "R2/R3/R4/R5/R8", sd, ev_sd);
          end
          ct++;
        end
        prev_sck = sck;
        if (s_ready) begin
          // R9: ready exactly at frame boundary
          if (nf == 0) chk(ct == 0, "R9", ct, 0);
          else chk(cf == nf - 1 && ct == 2 * slen(f_slot[cf]), "R9", ct, 2 * slen(f_slot[cf]));
          if (nf < 8) begin
            f_slot[nf] = slot_sel; f_w[nf] = width_sel; f_rj[nf] = rjust;
            f_lsb[nf] = lsb_first; f_fmt[nf] = fmt;
            if (s_valid) begin f_l[nf] = drv_l; f_r[nf] = drv_r; end
            else begin
              f_l[nf] = (nf == 0) ? 24'h0 : f_l[nf - 1];
              f_r[nf] = (nf == 0) ? 24'h0 : f_r[nf - 1];
              exp_ur = 1;
            end
          end
          nf++;
          pend = 1;
        end
      end
    end
  end

  task automatic set_cfg(int sl, int w, int rj, int lf, int fm, int dv);
    slot_sel = 2'(sl); width_sel = 2'(w); rjust = rj[0]; lsb_first = lf[0];
    fmt = 2'(fm); div = 8'(dv);
  endtask

  task automatic run(int sl, int w, int rj, int lf, int fm, int dv, int nfr, int urf);
    @(posedge clk); #1;
    en = 0; set_cfg(sl, w, rj, lf, fm, dv); ur_frame = urf; seed++;
    repeat (3) @(posedge clk);
    #1 en = 1;
    while (nf < nfr + 1) @(posedge clk);
    #1 en = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk(!sck && !ws && !sd && !underrun && !s_ready, "R12", {sck, ws, sd, underrun, s_ready}, 0);
    @(posedge clk); #1 rst_ni = 1;
    repeat (2) @(posedge clk);

    // full sweep over every setting combination
    ctx = "sweep";
    for (int sl = 0; sl < 3; sl++)
      for (int w = 0; w < 4; w++)
        for (int rj = 0; rj < 2; rj++)
          for (int lf = 0; lf < 2; lf++)
            for (int fm = 0; fm < 3; fm++)
              run(sl, w, rj, lf, fm, (sl + w + fm) % 2, 2, -1);

    // reserved format code behaves as delayed format, wider divider
    ctx = "fmt3";
    run(2, 3, 1, 0, 3, 2, 2, -1);

    // R10: withhold valid for frame 1
    ctx = "R10 underrun";
    run(1, 2, 0, 0, 0, 1, 3, 1);

    // R11: settings change mid-frame
    ctx = "R11 mid-frame change";
    @(posedge clk); #1;
    en = 0; set_cfg(2, 3, 0, 0, 0, 0); ur_frame = -1; seed++;
    repeat (3) @(posedge clk);
    #1 en = 1;
    while (!(cf == 0 && ct >= 10)) @(posedge clk);
    #1 set_cfg(0, 0, 1, 1, 2, 0);
    while (nf < 4) @(posedge clk);
    #1 en = 0;
    repeat (4) @(posedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule